// File: doc/BRIEF.md
# Eight-Level Vectored Interrupt Controller

This block sits between the interrupt sources of a small controller and its CPU. A set of source request lines comes in, from on-chip peripherals or from external pins. A separate software-interrupt command also comes in and carries its own level. Each source has a mask bit and a three-bit level field. An unmasked request sets the pending bit of the level assigned to that source. When two sources share a level, they share that one pending bit.

Among the pending levels, the highest number wins; level 7 is the most urgent. The block raises `irq` and presents the winning level and its service vector. The vector is a fixed base address plus the level times a fixed stride. The CPU takes the interrupt by pulsing `irq_ack`. This clears the pending bit and marks the level as in service. The CPU pulses `svc_done` when the routine returns.

While a level is in service, only a strictly higher level can interrupt it, so routines nest by priority. When the global enable input is low, `irq` is held low but requests are still recorded. Service then starts as soon as the enable returns.

Top module: `lvl8_irq_arb`

## Requirements
- R1: When `irq` is high, `irq_lvl` is the highest-numbered pending level (7 highest, 0 lowest). Two sources assigned to the same level share one pending bit, so one acknowledge serves both.
- R2: When `irq` is high, `vec` equals `VEC_BASE + irq_lvl * VEC_STRIDE` (defaults 12'h040 and 8).
- R3: A source request with its mask bit at 0 sets, at the next clock edge, the pending bit of the level in its field `src_level[3*i+2:3*i]`. `irq` can rise in the cycle after the request.
- R4: A source request with its mask bit at 1 is ignored. No pending bit is set, which shows as `irq` staying low.
- R5: `sw_req` sets the pending bit of level `sw_level`, whatever the source masks are.
- R6: While `gie` is 0, `irq` is 0, and requests keep being recorded. When `gie` returns to 1, the highest pending level is presented in that same cycle.
- R7: `irq_ack` while `irq` is high clears the presented level's pending bit and marks that level in service. `irq_ack` while `irq` is low has no effect.
- R8: While levels are in service, `irq` is raised only for a pending level above the highest in-service level. Equal or lower levels wait.
- R9: `svc_done` ends service of the highest in-service level. Any lower levels that are still in service or pending then take effect again.
- R10: A request that arrives in the cycle its level is acknowledged leaves that level pending.
- R11: While `rst_n` is low, all pending and in-service state is cleared and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_req | input | N_SRC | Request strobes, one per source |
| src_mask | input | N_SRC | 1 = source masked |
| src_level | input | N_SRC*3 | Level field of each source, source i at bits [3i+2:3i] |
| sw_req | input | 1 | Software interrupt strobe |
| sw_level | input | 3 | Level of the software interrupt |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | CPU takes the presented interrupt |
| svc_done | input | 1 | CPU ends the current service routine |
| irq | output | 1 | Interrupt request to the CPU |
| irq_lvl | output | 3 | Level being presented |
| vec | output | VEC_W | Service vector of the presented level |

## Verification
The assertions assume the CPU side follows the handshake:
- it never pulses `irq_ack` and `svc_done` in the same cycle;
- it pulses `svc_done` only while a routine it has taken is still open.

The directed part of the bench and its random section both obey these rules. The random section draws an acknowledge only in cycles where the reference model predicts `irq`. It draws an end-of-service only when the model's service set is non-empty and no acknowledge is driven that cycle. Source strobes, masks and the enable toggle freely, because any combination of them is legal input.

// File: rtl/vic_pkg.sv
// Shared constants and types for the eight-level interrupt controller.
// Assumes a fixed count of eight priority levels; the source count is a
// parameter of the modules that use it.
package vic_pkg;
    localparam int N_LVL = 8;
    localparam int LVL_W = $clog2(N_LVL);
    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [N_LVL-1:0] lvl_vec_t;
endpackage

// File: rtl/vic_src_map.sv
// Maps source and software requests onto a per-level set vector.
// Assumes requests are single-cycle strobes; masked sources contribute
// nothing, and the software interrupt ignores the masks.
module vic_src_map
    import vic_pkg::*;
#(
    parameter int N_SRC = 6
) (
    input  logic [N_SRC-1:0]       src_req,
    input  logic [N_SRC-1:0]       src_mask,
    input  logic [N_SRC*LVL_W-1:0] src_level,
    input  logic                   sw_req,
    input  lvl_t                   sw_level,
    output lvl_vec_t               set_vec
);
    logic [N_SRC-1:0] live;

    // Qualify each source strobe by its mask bit.
    assign live = src_req & ~src_mask;

    // Build the set vector: one OR-tree per level over matching sources.
    genvar g;
    generate
        for (g = 0; g < N_LVL; g++) begin : g_lvl
            logic hit;
            always_comb begin
                hit = sw_req && (sw_level == lvl_t'(g));
                for (int s = 0; s < N_SRC; s++) begin
                    if (live[s] && (src_level[s*LVL_W +: LVL_W] == lvl_t'(g)))
                        hit = 1'b1;
                end
            end
            assign set_vec[g] = hit;
        end
    endgenerate
endmodule

// File: rtl/vic_prio_enc.sv
// Highest-set-bit priority encoder.
// Assumes the upper bit index is the more urgent one; idx is zero when
// no bit is set and any is low.
module vic_prio_enc #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  in_vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan upward so the last (highest) set bit is kept.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (in_vec[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vic_state.sv
// Pending and in-service level registers.
// Assumes take and drop refer to different levels in any one cycle. A new
// set wins over a clear of the same pending bit.
module vic_state
    import vic_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lvl_vec_t set_vec,
    input  logic     take,
    input  lvl_t     take_lvl,
    input  logic     drop,
    input  lvl_t     drop_lvl,
    output lvl_vec_t pend_q,
    output lvl_vec_t insvc_q
);
    lvl_vec_t take_mask;
    lvl_vec_t drop_mask;

    // Decode the taken and dropped levels into one-hot masks.
    always_comb begin
        take_mask = '0;
        drop_mask = '0;
        for (int i = 0; i < N_LVL; i++) begin
            if (take && (take_lvl == lvl_t'(i))) take_mask[i] = 1'b1;
            if (drop && (drop_lvl == lvl_t'(i))) drop_mask[i] = 1'b1;
        end
    end

    // Update the pending and in-service sets each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            insvc_q <= '0;
        end else begin
            pend_q  <= (pend_q & ~take_mask) | set_vec;
            insvc_q <= (insvc_q & ~drop_mask) | take_mask;
        end
    end
endmodule

// File: rtl/lvl8_irq_arb.sv
// Eight-level vectored interrupt arbiter.
// Gathers masked source requests and a software request into per-level
// pending bits. It presents the highest pending level above the current
// service level while the global enable is set, and tracks nested service.
// Assumes irq_ack and svc_done are never high in the same cycle.
module lvl8_irq_arb
    import vic_pkg::*;
#(
    parameter int               N_SRC      = 6,
    parameter int               VEC_W      = 12,
    parameter logic [VEC_W-1:0] VEC_BASE   = 12'h040,
    parameter int               VEC_STRIDE = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       src_req,
    input  logic [N_SRC-1:0]       src_mask,
    input  logic [N_SRC*LVL_W-1:0] src_level,
    input  logic                   sw_req,
    input  logic [LVL_W-1:0]       sw_level,
    input  logic                   gie,
    input  logic                   irq_ack,
    input  logic                   svc_done,
    output logic                   irq,
    output logic [LVL_W-1:0]       irq_lvl,
    output logic [VEC_W-1:0]       vec
);
    lvl_vec_t set_vec;
    lvl_vec_t pend_q;
    lvl_vec_t insvc_q;
    logic     pend_any;
    lvl_t     win_lvl;
    logic     svc_any;
    lvl_t     svc_lvl;
    logic     take;

    vic_src_map #(.N_SRC(N_SRC)) u_map (
        .src_req  (src_req),
        .src_mask (src_mask),
        .src_level(src_level),
        .sw_req   (sw_req),
        .sw_level (sw_level),
        .set_vec  (set_vec)
    );

    vic_prio_enc #(.W(N_LVL), .IW(LVL_W)) u_pend_enc (
        .in_vec(pend_q),
        .any   (pend_any),
        .idx   (win_lvl)
    );

    vic_prio_enc #(.W(N_LVL), .IW(LVL_W)) u_svc_enc (
        .in_vec(insvc_q),
        .any   (svc_any),
        .idx   (svc_lvl)
    );

    // Request the CPU only for an enabled winner above the service level.
    always_comb begin
        irq  = gie && pend_any && (!svc_any || (win_lvl > svc_lvl));
        take = irq && irq_ack;
    end

    vic_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .take    (take),
        .take_lvl(win_lvl),
        .drop    (svc_done && svc_any),
        .drop_lvl(svc_lvl),
        .pend_q  (pend_q),
        .insvc_q (insvc_q)
    );

    // Form the level and vector outputs from the winning level.
    assign irq_lvl = win_lvl;
    assign vec     = VEC_BASE + VEC_W'(win_lvl) * VEC_W'(VEC_STRIDE);
endmodule

// File: rtl/vic_chk.sv
// Assertion checker for lvl8_irq_arb, attached through bind.
// Assumes the CPU never acknowledges and ends service in the same cycle.
module vic_chk
    import vic_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     gie,
    input logic     irq_ack,
    input logic     irq,
    input lvl_t     irq_lvl,
    input lvl_vec_t pend_q,
    input lvl_vec_t insvc_q,
    input lvl_vec_t set_vec,
    input logic     svc_any,
    input lvl_t     svc_lvl
);
    // R6: the enable gates the request line
    a_r6_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq);

    // R1: the presented level is pending and nothing above it is
    a_r1_lvl_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend_q[irq_lvl]);

    a_r1_none_higher: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (((pend_q >> irq_lvl) >> 1) == '0));

    // R8: only a level above the service level is presented
    a_r8_above_service: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && svc_any) |-> (irq_lvl > svc_lvl));

    // R7: a taken level leaves pending and enters service
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack && !set_vec[irq_lvl]) |=> !pend_q[$past(irq_lvl)]);

    a_r7_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack) |=> insvc_q[$past(irq_lvl)]);

    // R3: without an acknowledge no pending bit is lost
    a_r3_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && irq_ack) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

bind lvl8_irq_arb vic_chk u_vic_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .gie    (gie),
    .irq_ack(irq_ack),
    .irq    (irq),
    .irq_lvl(irq_lvl),
    .pend_q (pend_q),
    .insvc_q(insvc_q),
    .set_vec(set_vec),
    .svc_any(svc_any),
    .svc_lvl(svc_lvl)
);

// File: tb/test_lvl8_irq_arb.sv
`timescale 1ns/100ps
module test_lvl8_irq_arb;
    localparam int NS = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NS-1:0] src_req;
    logic [NS-1:0] src_mask;
    logic [NS*3-1:0] src_level;
    logic          sw_req;
    logic [2:0]    sw_level;
    logic          gie;
    logic          irq_ack;
    logic          svc_done;
    logic          irq;
    logic [2:0]    irq_lvl;
    logic [11:0]   vec;

    int    n_vec = 0;
    int    n_bad = 0;
    string tag   = "R11";
    logic [7:0] m_pend = '0;
    logic [7:0] m_ins  = '0;

    always #2.5 clk = ~clk;

    lvl8_irq_arb i_lvl8_irq_arb (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_mask(src_mask),
        .src_level(src_level), .sw_req(sw_req), .sw_level(sw_level),
        .gie(gie), .irq_ack(irq_ack), .svc_done(svc_done),
        .irq(irq), .irq_lvl(irq_lvl), .vec(vec)
    );

    function automatic int top_bit(logic [7:0] v);
        int r = -1;
        for (int i = 0; i < 8; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic bit exp_irq();
        int w = top_bit(m_pend);
        int s = top_bit(m_ins);
        return gie && (w >= 0) && (w > s);
    endfunction

    // Compare against the model, then advance the model and the clock.
    task automatic tick();
        int  w, s;
        bit  e;
        logic [11:0] ev;
        logic [7:0] setv;
        #1;
        w  = top_bit(m_pend);
        s  = top_bit(m_ins);
        e  = exp_irq();
        ev = 12'h040 + 12'(w * 8);
        n_vec++;
        if (irq !== e || (e && (irq_lvl !== 3'(w) || vec !== ev))) begin
            n_bad++;
            $display("FAIL %s: irq=%b lvl=%0d vec=%h expected irq=%b lvl=%0d vec=%h",
                     tag, irq, irq_lvl, vec, e, w, ev);
        end
        setv = '0;
        for (int i = 0; i < NS; i++)
            if (src_req[i] && !src_mask[i]) setv[src_level[i*3 +: 3]] = 1'b1;
        if (sw_req) setv[sw_level] = 1'b1;
        @(posedge clk);
        if (!rst_n) begin
            m_pend = '0;
            m_ins  = '0;
        end else begin
            if (svc_done && s >= 0) m_ins[s] = 1'b0;
            if (irq_ack && e) begin
                m_ins[w]  = 1'b1;
                m_pend[w] = 1'b0;
            end
            m_pend = m_pend | setv;
        end
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse_src(logic [NS-1:0] m);
        src_req = m; tick(); src_req = '0;
    endtask

    task automatic ack();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    endtask

    task automatic done();
        svc_done = 1'b1; tick(); svc_done = 1'b0;
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; src_req = '0; src_mask = '0; sw_req = 1'b0; sw_level = '0;
        gie = 1'b1; irq_ack = 1'b0; svc_done = 1'b0;
        // levels: s0->1, s1->3, s2->3, s3->5, s4->6, s5->0
        src_level = {3'd0, 3'd6, 3'd5, 3'd3, 3'd3, 3'd1};
        @(negedge clk);
        tag = "R11"; pulse_src(6'b000010); idle(2);
        rst_n = 1'b1; idle(1);

        tag = "R3"; pulse_src(6'b000010); idle(1);
        tag = "R2"; ack(); idle(1);
        tag = "R9"; done(); idle(1);

        tag = "R4"; src_mask = 6'b001000; pulse_src(6'b001000); idle(3);
        tag = "R5"; src_mask = '1; sw_level = 3'd7; sw_req = 1'b1; tick(); sw_req = 1'b0;
        idle(1); ack(); done(); src_mask = '0;

        tag = "R6"; gie = 1'b0; pulse_src(6'b010001); idle(2);
        tag = "R7"; ack(); idle(1);
        tag = "R6"; gie = 1'b1; tick();
        ack();
        tag = "R8"; idle(2); done(); idle(1); ack(); done();

        tag = "R8"; pulse_src(6'b000001); ack(); pulse_src(6'b000010); ack();
        pulse_src(6'b000100); idle(2);
        tag = "R9"; done(); idle(1); ack(); done(); done(); idle(1);

        tag = "R1"; pulse_src(6'b000110); ack(); idle(2); done(); idle(1);
        pulse_src(6'b011001); ack(); ack(); ack(); done(); done(); done();

        tag = "R10"; pulse_src(6'b000001); src_req = 6'b000001; irq_ack = 1'b1; tick();
        src_req = '0; irq_ack = 1'b0; idle(1); done(); ack(); done();

        tag = "R8";
        for (int c = 0; c < 3000; c++) begin
            src_req  = ($urandom_range(0, 3) == 0) ? NS'($urandom) : '0;
            src_mask = ($urandom_range(0, 7) == 0) ? NS'($urandom) : src_mask;
            sw_req   = ($urandom_range(0, 15) == 0);
            sw_level = 3'($urandom);
            gie      = ($urandom_range(0, 9) != 0);
            irq_ack  = exp_irq() && ($urandom_range(0, 1) == 0);
            svc_done = !irq_ack && (m_ins != 0) && ($urandom_range(0, 3) == 0);
            tick();
        end
        src_req = '0; sw_req = 1'b0; irq_ack = 1'b0; svc_done = 1'b0;
        idle(2);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule